// File: doc/BRIEF.md
# Microcoded Register Datapath with Shared Result Bus

This block is the execution half of a horizontally microcoded stack processor. Each cycle a control word picks one register to place on a single-source operand bus, an ALU combines that operand with a dedicated accumulator register called hold, and a shifter post-processes the ALU output. The shifted value becomes the result bus. Any subset of nine destination registers can capture the result bus at the clock edge that ends the cycle.

The block also takes the data that returns from memory. A full word goes into the memory data register, and a single byte goes into an 8-bit fetch-byte register that can be read back sign-extended or zero-extended. The ALU's negative and zero indications come out as flags for a sequencer to branch on. Next-address logic and memory request generation live outside this block.

Top module: `mstk_datapath`

## Requirements
- R1: While `rst` is high at a clock edge, every register, including the fetch byte, becomes zero.
- R2: Operand-bus select codes: 0 mem_data, 1 pgm_ctr, 2 fetch byte sign-extended, 3 fetch byte zero-extended, 4 stack_ptr, 5 frame_base, 6 const_base, 7 top_word, 8 scratch. Codes 9 to 15 supply zero.
- R3: `alu_field` layout: bits [1:0] select the function (00 A AND B, 01 A OR B, 10 NOT B, 11 A plus B). Bit 2 enables A (hold) and bit 3 enables B (operand bus); a disabled input is zero. Bit 4 inverts A after the enable is applied.
- R4: Bit 5 of `alu_field` adds a carry-in of one, only for the add function. The other functions ignore it.
- R5: Bit 6 of `alu_field` shifts the ALU result left by 8 with zero fill. Bit 7 shifts it right by 1 arithmetically. When both bits are set, the result passes unshifted.
- R6: `neg_flag` equals bit 31 of the ALU result before the shifter. `zero_flag` is high exactly when that pre-shift result is zero.
- R7: `cwrite` bit order: 0 hold, 1 scratch, 2 top_word, 3 const_base, 4 frame_base, 5 stack_ptr, 6 pgm_ctr, 7 mem_data, 8 mem_addr. Every enabled destination loads `cbus` at the clock edge. Destinations that are not enabled keep their value.
- R8: When `mem_word_valid` is high, mem_data loads `mem_word`, and this overrides a result-bus write to mem_data. When `mem_byte_valid` is high, the fetch byte loads `mem_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_field | input | 8 | Function, input gating, inversion, carry-in and shift control |
| bsel | input | 4 | Operand-bus source code |
| cwrite | input | 9 | Destination write enables |
| mem_word_valid | input | 1 | Returned memory word is valid |
| mem_word | input | 32 | Returned memory word |
| mem_byte_valid | input | 1 | Returned fetch byte is valid |
| mem_byte | input | 8 | Returned fetch byte |
| hold_o | output | 32 | Accumulator (ALU A input) |
| scratch_o | output | 32 | Scratch register |
| top_o | output | 32 | Top-of-stack copy |
| cbase_o | output | 32 | Constant pool base |
| frame_o | output | 32 | Local frame base |
| sp_o | output | 32 | Stack pointer |
| pc_o | output | 32 | Program counter |
| mdata_o | output | 32 | Memory data register |
| maddr_o | output | 32 | Memory address register |
| byte_o | output | 8 | Fetch byte register |
| neg_flag | output | 1 | Pre-shift result is negative |
| zero_flag | output | 1 | Pre-shift result is zero |
| cbus | output | 32 | Shifted result bus |

## Verification
The bench builds the block with its default 32-bit word and 8-bit fetch byte. With those values the sign bit of the word and the 8-place left shift land at positions the bench can reach directly. A value of 0x00800000 shifts into bit 31, which makes the flags observably differ from the shifted result. A fetch byte with its top bit set makes sign extension and zero extension give visibly different words. Seeded random control words, including the illegal double shift, then run against a bench model of every register.

// File: rtl/mstk_pkg.sv
package mstk_pkg;

    localparam int NUM_DEST = 9;
    localparam int BSEL_W   = 4;

    localparam int D_HOLD    = 0;
    localparam int D_SCRATCH = 1;
    localparam int D_TOP     = 2;
    localparam int D_CBASE   = 3;
    localparam int D_FRAME   = 4;
    localparam int D_SP      = 5;
    localparam int D_PC      = 6;
    localparam int D_MDATA   = 7;
    localparam int D_MADDR   = 8;

    typedef enum logic [1:0] {
        FN_AND  = 2'b00,
        FN_OR   = 2'b01,
        FN_NOTB = 2'b10,
        FN_ADD  = 2'b11
    } alu_fn_e;

    typedef struct packed {
        logic    sar1;
        logic    shl8;
        logic    cin;
        logic    inv_a;
        logic    b_en;
        logic    a_en;
        alu_fn_e fn;
    } alu_ctl_t;

    typedef enum logic [BSEL_W-1:0] {
        BS_MDATA   = 4'd0,
        BS_PC      = 4'd1,
        BS_BYTE_S  = 4'd2,
        BS_BYTE_Z  = 4'd3,
        BS_SP      = 4'd4,
        BS_FRAME   = 4'd5,
        BS_CBASE   = 4'd6,
        BS_TOP     = 4'd7,
        BS_SCRATCH = 4'd8
    } bsrc_e;

    function automatic logic shift_conflict(alu_ctl_t c);
        return c.shl8 && c.sar1;
    endfunction

endpackage

// File: rtl/mstk_bsrc_mux.sv
module mstk_bsrc_mux
    import mstk_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int BYTE_W = 8
) (
    input  logic [BSEL_W-1:0] bsel,
    input  logic [WIDTH-1:0]  regs [NUM_DEST],
    input  logic [BYTE_W-1:0] byte_reg,
    output logic [WIDTH-1:0]  bbus
);
    localparam int EXT_W = WIDTH - BYTE_W;

    logic [WIDTH-1:0] byte_sext;
    logic [WIDTH-1:0] byte_zext;

    assign byte_sext = {{EXT_W{byte_reg[BYTE_W-1]}}, byte_reg};
    assign byte_zext = {{EXT_W{1'b0}}, byte_reg};

    always_comb begin
        case (bsrc_e'(bsel))
            BS_MDATA:   bbus = regs[D_MDATA];
            BS_PC:      bbus = regs[D_PC];
            BS_BYTE_S:  bbus = byte_sext;
            BS_BYTE_Z:  bbus = byte_zext;
            BS_SP:      bbus = regs[D_SP];
            BS_FRAME:   bbus = regs[D_FRAME];
            BS_CBASE:   bbus = regs[D_CBASE];
            BS_TOP:     bbus = regs[D_TOP];
            BS_SCRATCH: bbus = regs[D_SCRATCH];
            default:    bbus = '0;
        endcase
    end
endmodule

// File: rtl/mstk_alu.sv
module mstk_alu
    import mstk_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_ctl_t         ctl,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] result,
    output logic             neg,
    output logic             zero
);
    logic [WIDTH-1:0] a_gated;
    logic [WIDTH-1:0] a_op;
    logic [WIDTH-1:0] b_op;
    logic [WIDTH-1:0] carry;

    assign a_gated = ctl.a_en ? a_in : '0;
    assign a_op    = ctl.inv_a ? ~a_gated : a_gated;
    assign b_op    = ctl.b_en ? b_in : '0;
    assign carry   = {{(WIDTH-1){1'b0}}, ctl.cin};

    always_comb begin
        case (ctl.fn)
            FN_AND:  result = a_op & b_op;
            FN_OR:   result = a_op | b_op;
            FN_NOTB: result = ~b_op;
            default: result = a_op + b_op + carry;
        endcase
    end

    assign neg  = result[WIDTH-1];
    assign zero = (result == '0);
endmodule

// File: rtl/mstk_shifter.sv
module mstk_shifter
    import mstk_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int SHL_AMT = 8
) (
    input  alu_ctl_t         ctl,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] left_v;
    logic [WIDTH-1:0] right_v;

    assign left_v  = din << SHL_AMT;
    assign right_v = {din[WIDTH-1], din[WIDTH-1:1]};

    always_comb begin
        if (shift_conflict(ctl))
            dout = din;
        else if (ctl.shl8)
            dout = left_v;
        else if (ctl.sar1)
            dout = right_v;
        else
            dout = din;
    end
endmodule

// File: rtl/mstk_datapath.sv
module mstk_datapath
    import mstk_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int BYTE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [7:0]           alu_field,
    input  logic [BSEL_W-1:0]    bsel,
    input  logic [NUM_DEST-1:0]  cwrite,
    input  logic                 mem_word_valid,
    input  logic [WIDTH-1:0]     mem_word,
    input  logic                 mem_byte_valid,
    input  logic [BYTE_W-1:0]    mem_byte,
    output logic [WIDTH-1:0]     hold_o,
    output logic [WIDTH-1:0]     scratch_o,
    output logic [WIDTH-1:0]     top_o,
    output logic [WIDTH-1:0]     cbase_o,
    output logic [WIDTH-1:0]     frame_o,
    output logic [WIDTH-1:0]     sp_o,
    output logic [WIDTH-1:0]     pc_o,
    output logic [WIDTH-1:0]     mdata_o,
    output logic [WIDTH-1:0]     maddr_o,
    output logic [BYTE_W-1:0]    byte_o,
    output logic                 neg_flag,
    output logic                 zero_flag,
    output logic [WIDTH-1:0]     cbus
);
    alu_ctl_t          ctl;
    logic [WIDTH-1:0]  regs_q [NUM_DEST];
    logic [BYTE_W-1:0] byte_q;
    logic [WIDTH-1:0]  bbus;
    logic [WIDTH-1:0]  alu_res;

    assign ctl = alu_ctl_t'(alu_field);

    mstk_bsrc_mux #(.WIDTH(WIDTH), .BYTE_W(BYTE_W)) u_bsrc (
        .bsel     (bsel),
        .regs     (regs_q),
        .byte_reg (byte_q),
        .bbus     (bbus)
    );

    mstk_alu #(.WIDTH(WIDTH)) u_alu (
        .ctl    (ctl),
        .a_in   (regs_q[D_HOLD]),
        .b_in   (bbus),
        .result (alu_res),
        .neg    (neg_flag),
        .zero   (zero_flag)
    );

    mstk_shifter #(.WIDTH(WIDTH), .SHL_AMT(BYTE_W)) u_shift (
        .ctl  (ctl),
        .din  (alu_res),
        .dout (cbus)
    );

    for (genvar gi = 0; gi < NUM_DEST; gi++) begin : g_dest
        if (gi == D_MDATA) begin : g_mem_port
            always_ff @(posedge clk) begin
                if (rst)
                    regs_q[gi] <= '0;
                else if (mem_word_valid)
                    regs_q[gi] <= mem_word;
                else if (cwrite[gi])
                    regs_q[gi] <= cbus;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)
                    regs_q[gi] <= '0;
                else if (cwrite[gi])
                    regs_q[gi] <= cbus;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            byte_q <= '0;
        else if (mem_byte_valid)
            byte_q <= mem_byte;
    end

    assign hold_o    = regs_q[D_HOLD];
    assign scratch_o = regs_q[D_SCRATCH];
    assign top_o     = regs_q[D_TOP];
    assign cbase_o   = regs_q[D_CBASE];
    assign frame_o   = regs_q[D_FRAME];
    assign sp_o      = regs_q[D_SP];
    assign pc_o      = regs_q[D_PC];
    assign mdata_o   = regs_q[D_MDATA];
    assign maddr_o   = regs_q[D_MADDR];
    assign byte_o    = byte_q;
endmodule

// File: rtl/mstk_datapath_chk.sv
module mstk_datapath_chk
    import mstk_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [7:0]          alu_field,
    input logic [BSEL_W-1:0]   bsel,
    input logic [NUM_DEST-1:0] cwrite,
    input logic                mem_word_valid,
    input logic [WIDTH-1:0]    mem_word,
    input logic [WIDTH-1:0]    hold_o,
    input logic [WIDTH-1:0]    sp_o,
    input logic [WIDTH-1:0]    mdata_o,
    input logic                neg_flag,
    input logic                zero_flag,
    input logic [WIDTH-1:0]    cbus,
    input logic [WIDTH-1:0]    alu_res
);
    alu_ctl_t c;
    assign c = alu_ctl_t'(alu_field);

    a_r7_hold_captures: assert property (@(posedge clk) disable iff (rst)
        cwrite[D_HOLD] |=> hold_o == $past(cbus));

    a_r7_sp_keeps: assert property (@(posedge clk) disable iff (rst)
        !cwrite[D_SP] |=> $stable(sp_o));

    a_r8_word_overrides: assert property (@(posedge clk) disable iff (rst)
        mem_word_valid |=> mdata_o == $past(mem_word));

    a_r5_conflict_unshifted: assert property (@(posedge clk) disable iff (rst)
        (c.shl8 && c.sar1) |-> cbus == alu_res);

    a_r5_left_fill_zero: assert property (@(posedge clk) disable iff (rst)
        (c.shl8 && !c.sar1) |-> cbus[BYTE_W-1:0] == '0);

    a_r2_unused_code_zero: assert property (@(posedge clk) disable iff (rst)
        (bsel > 4'd8 && c.fn == FN_OR && !c.a_en && !c.inv_a) |-> (alu_res == '0 && zero_flag));

    a_r6_masked_and_zero: assert property (@(posedge clk) disable iff (rst)
        (c.fn == FN_AND && !c.a_en && !c.inv_a) |-> (zero_flag && !neg_flag));
endmodule

bind mstk_datapath mstk_datapath_chk #(.WIDTH(WIDTH), .BYTE_W(BYTE_W)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .alu_field      (alu_field),
    .bsel           (bsel),
    .cwrite         (cwrite),
    .mem_word_valid (mem_word_valid),
    .mem_word       (mem_word),
    .hold_o         (hold_o),
    .sp_o           (sp_o),
    .mdata_o        (mdata_o),
    .neg_flag       (neg_flag),
    .zero_flag      (zero_flag),
    .cbus           (cbus),
    .alu_res        (alu_res)
);

// File: tb/mstk_datapath_tb.sv
module mstk_datapath_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  alu_field = '0;
    logic [3:0]  bsel = '0;
    logic [8:0]  cwrite = '0;
    logic        mem_word_valid = 1'b0;
    logic [31:0] mem_word = '0;
    logic        mem_byte_valid = 1'b0;
    logic [7:0]  mem_byte = '0;
    logic [31:0] hold_o, scratch_o, top_o, cbase_o, frame_o, sp_o, pc_o, mdata_o, maddr_o;
    logic [7:0]  byte_o;
    logic        neg_flag, zero_flag;
    logic [31:0] cbus;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] m_reg [9];
    logic [7:0]  m_byte;
    logic [31:0] d_reg [9];

    always #5 clk = ~clk;

    mstk_datapath dut_i (
        .clk(clk), .rst(rst), .alu_field(alu_field), .bsel(bsel), .cwrite(cwrite),
        .mem_word_valid(mem_word_valid), .mem_word(mem_word),
        .mem_byte_valid(mem_byte_valid), .mem_byte(mem_byte),
        .hold_o(hold_o), .scratch_o(scratch_o), .top_o(top_o), .cbase_o(cbase_o),
        .frame_o(frame_o), .sp_o(sp_o), .pc_o(pc_o), .mdata_o(mdata_o),
        .maddr_o(maddr_o), .byte_o(byte_o), .neg_flag(neg_flag),
        .zero_flag(zero_flag), .cbus(cbus)
    );

    assign d_reg[0] = hold_o;  assign d_reg[1] = scratch_o; assign d_reg[2] = top_o;
    assign d_reg[3] = cbase_o; assign d_reg[4] = frame_o;   assign d_reg[5] = sp_o;
    assign d_reg[6] = pc_o;    assign d_reg[7] = mdata_o;   assign d_reg[8] = maddr_o;

    function automatic logic [7:0] mk(input logic [1:0] fn, input bit aen, input bit ben,
                                      input bit inva, input bit cin, input bit shl, input bit sar);
        return {sar, shl, cin, inva, ben, aen, fn};
    endfunction

    function automatic logic [31:0] exp_bbus(input logic [3:0] code);
        case (code)
            4'd0: return m_reg[7];
            4'd1: return m_reg[6];
            4'd2: return {{24{m_byte[7]}}, m_byte};
            4'd3: return {24'd0, m_byte};
            4'd4: return m_reg[5];
            4'd5: return m_reg[4];
            4'd6: return m_reg[3];
            4'd7: return m_reg[2];
            4'd8: return m_reg[1];
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] exp_alu(input logic [7:0] f, input logic [3:0] code);
        logic [31:0] a, b;
        a = f[2] ? m_reg[0] : 32'd0;
        if (f[4]) a = ~a;
        b = f[3] ? exp_bbus(code) : 32'd0;
        case (f[1:0])
            2'b00: return a & b;
            2'b01: return a | b;
            2'b10: return ~b;
            default: return a + b + {31'd0, f[5]};
        endcase
    endfunction

    function automatic logic [31:0] exp_shift(input logic [7:0] f, input logic [31:0] v);
        if (f[6] && f[7]) return v;
        if (f[6]) return v << 8;
        if (f[7]) return {v[31], v[31:1]};
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] f, input logic [3:0] code, input logic [8:0] cw,
                        input bit wv, input logic [31:0] w, input bit bv, input logic [7:0] bt,
                        input string req);
        logic [31:0] r, c;
        @(negedge clk);
        alu_field = f; bsel = code; cwrite = cw;
        mem_word_valid = wv; mem_word = w; mem_byte_valid = bv; mem_byte = bt;
        #1;
        r = exp_alu(f, code);
        c = exp_shift(f, r);
        chk(cbus === c, req, "cbus", cbus, c);
        chk(neg_flag === r[31], "R6", "neg_flag", {31'd0, neg_flag}, {31'd0, r[31]});
        chk(zero_flag === (r == 0), "R6", "zero_flag", {31'd0, zero_flag}, {31'd0, r == 0});
        @(posedge clk);
        #1;
        for (int i = 0; i < 9; i++)
            if (cw[i]) m_reg[i] = c;
        if (wv) m_reg[7] = w;
        if (bv) m_byte = bt;
        for (int i = 0; i < 9; i++)
            chk(d_reg[i] === m_reg[i], (i == 7) ? "R8" : "R7", $sformatf("reg%0d", i), d_reg[i], m_reg[i]);
        chk(byte_o === m_byte, "R8", "fetch byte", {24'd0, byte_o}, {24'd0, m_byte});
    endtask

    localparam logic [7:0] PASS_B = 8'b0000_1001;

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0A17));
        for (int i = 0; i < 9; i++) m_reg[i] = '0;
        m_byte = '0;
        cwrite = 9'h1FF;
        mem_word_valid = 1'b1; mem_word = 32'hDEAD_BEEF;
        mem_byte_valid = 1'b1; mem_byte = 8'hAA;
        repeat (3) @(posedge clk);
        #1;
        for (int i = 0; i < 9; i++)
            chk(d_reg[i] === 32'd0, "R1", $sformatf("reset reg%0d", i), d_reg[i], 32'd0);
        chk(byte_o === 8'd0, "R1", "reset byte", {24'd0, byte_o}, 32'd0);
        @(negedge clk);
        rst = 1'b0; cwrite = '0; mem_word_valid = 1'b0; mem_byte_valid = 1'b0;

        // R8: memory word beats a result-bus write to mem_data; byte load
        step(PASS_B, 4'd9, 9'h080, 1'b1, 32'h1234_5678, 1'b1, 8'h9C, "R8");

        // fill each destination with a distinct value through mem_data
        for (int i = 0; i < 9; i++) begin
            if (i == 7) continue;
            step(8'h00, 4'd9, 9'h000, 1'b1, 32'h1111_1111 * (i + 1) + 32'h0F0F_0000, 1'b0, 8'h00, "R8");
            step(PASS_B, 4'd0, 9'h001 << i, 1'b0, 32'h0, 1'b0, 8'h00, "R7");
        end
        step(8'h00, 4'd9, 9'h000, 1'b1, 32'hFEDC_BA98, 1'b0, 8'h00, "R8");

        // R2: every operand-bus code, including unused ones
        for (int code = 0; code < 16; code++)
            step(PASS_B, code[3:0], 9'h000, 1'b0, 32'h0, 1'b0, 8'h00, "R2");

        // R3: functions, gating and inversion
        step(mk(2'b00, 1, 1, 0, 0, 0, 0), 4'd0, 9'h000, 0, 0, 0, 0, "R3");
        step(mk(2'b01, 1, 1, 0, 0, 0, 0), 4'd4, 9'h000, 0, 0, 0, 0, "R3");
        step(mk(2'b10, 1, 1, 0, 0, 0, 0), 4'd1, 9'h000, 0, 0, 0, 0, "R3");
        step(mk(2'b11, 1, 1, 0, 0, 0, 0), 4'd5, 9'h000, 0, 0, 0, 0, "R3");
        step(mk(2'b01, 0, 0, 1, 0, 0, 0), 4'd0, 9'h000, 0, 0, 0, 0, "R3");
        step(mk(2'b11, 1, 1, 1, 0, 0, 0), 4'd6, 9'h000, 0, 0, 0, 0, "R3");
        step(mk(2'b10, 1, 0, 0, 0, 0, 0), 4'd2, 9'h000, 0, 0, 0, 0, "R3");
        // R4: carry-in on add only
        step(mk(2'b11, 1, 1, 1, 1, 0, 0), 4'd7, 9'h000, 0, 0, 0, 0, "R4");
        step(mk(2'b11, 0, 0, 0, 1, 0, 0), 4'd0, 9'h000, 0, 0, 0, 0, "R4");
        step(mk(2'b00, 1, 1, 0, 1, 0, 0), 4'd0, 9'h000, 0, 0, 0, 0, "R4");
        step(mk(2'b01, 0, 0, 0, 1, 0, 0), 4'd0, 9'h000, 0, 0, 0, 0, "R4");

        // R5 / R6: shifts on a negative operand and a bit-23 operand
        step(8'h00, 4'd9, 9'h000, 1'b1, 32'h8000_00F1, 1'b0, 8'h00, "R8");
        step(mk(2'b01, 0, 1, 0, 0, 1, 0), 4'd0, 9'h000, 0, 0, 0, 0, "R5");
        step(mk(2'b01, 0, 1, 0, 0, 0, 1), 4'd0, 9'h000, 0, 0, 0, 0, "R5");
        step(mk(2'b01, 0, 1, 0, 0, 1, 1), 4'd0, 9'h000, 0, 0, 0, 0, "R5");
        step(8'h00, 4'd9, 9'h000, 1'b1, 32'h0080_0000, 1'b0, 8'h00, "R8");
        step(mk(2'b01, 0, 1, 0, 0, 1, 0), 4'd0, 9'h000, 0, 0, 0, 0, "R6");
        step(mk(2'b01, 0, 1, 0, 0, 0, 1), 4'd0, 9'h000, 0, 0, 0, 0, "R6");
        step(mk(2'b00, 0, 1, 0, 0, 0, 0), 4'd0, 9'h000, 0, 0, 0, 0, "R6");
        step(mk(2'b11, 0, 0, 1, 1, 0, 0), 4'd0, 9'h000, 0, 0, 0, 0, "R6");

        // R7: write every destination at once
        step(mk(2'b11, 1, 1, 0, 1, 0, 0), 4'd4, 9'h1FF, 0, 0, 0, 0, "R7");

        // seeded random mix
        for (int n = 0; n < 600; n++) begin
            logic [7:0]  rf;
            logic [3:0]  rc;
            logic [8:0]  rw;
            logic [31:0] rv;
            rf = $urandom();
            rc = $urandom_range(0, 15);
            rw = $urandom();
            rv = $urandom();
            step(rf, rc, rw, ($urandom_range(0, 3) == 0), rv,
                 ($urandom_range(0, 3) == 0), rv[15:8], "R7");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule